// File: doc/BRIEF.md
# Staggered Chip-Select Read Controller for Slow Serial Converters

This block runs a group of identical slow serial converters. Each converter has its own active-low chip-select. All converters share one serial clock. A converter begins a new conversion when its chip-select returns high, so the block alone decides when each conversion starts. To keep that control, every read stops before a full 32-bit word. This keeps the converter from starting a conversion by itself after the 32nd clock.

The block has two schedules. In staggered mode, one conversion period of `PERIOD` system cycles is divided into `N` slots of `PERIOD/N` cycles, and the last slot also takes the remainder. Each converter is read in its own slot, so the release edges fall evenly through the period and the combined output rate is `N` times that of one converter. In common mode, all chip-selects fall and rise on the same edges, so every converter samples at the same moment. One serial burst then captures all words in parallel.

Each captured word is handed out with its channel index on a valid/ready port. The sequencing is one state machine with four states:
- IDLE waits for a slot start.
- SELECT is a single setup cycle in which the shift lanes are cleared.
- SHIFT generates the serial clock and samples the data.
- DRAIN offers one channel index per cycle to the output register.

The transitions are:
- IDLE to SELECT: a slot starts and at least one chosen channel is ready.
- SELECT to SHIFT: always.
- SHIFT to DRAIN: on the last falling serial-clock edge.
- DRAIN to IDLE: after channel index `N-1`.

Top module: `ilv_adc_rdctl`

## Requirements
- R1: While `rst_n` is low, `cs_n` is all ones, `sck` is 0, `out_valid` is 0 and `ovf` is 0.
- R2: In staggered mode (`ilv_mode`=1), slot k starts when the period count equals k·(PERIOD/N). Only `cs_n[k]` is pulled low for that read. The next release edge belongs to channel (k+1) mod N. With fixed settings, the spacing between successive release edges is PERIOD/N cycles, and PERIOD/N plus the remainder from channel N-1 to channel 0.
- R3: In common mode (`ilv_mode`=0), all `cs_n` bits fall on the same edge and rise on the same edge once per period. The captured words are emitted in channel order 0 to N-1.
- R4: One read gives exactly n rising and n falling `sck` edges while the chip-select is low. n is `rd_len` limited to the range 1 to 31: 0 gives 1, and 32 or more gives 31. A 32nd falling edge never occurs.
- R5: Each `sck` half-period lasts `sck_div` system cycles, and 0 is treated as 1. `sdo` is sampled on the system edge that takes `sck` high.
- R6: `out_data` holds the n sampled bits, first bit as the most significant, right-aligned with zeros above. `out_chan` is the binary channel index.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_chan` hold their values.
- R8: A word offered while the output register is held and not being accepted is dropped, and `ovf` is high for one cycle for each dropped word.
- R9: A channel is read only if at least CONV_CYC cycles have passed since its last release edge. Otherwise its slot passes with no chip-select activity.
- R10: In staggered mode, at most one `cs_n` bit is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ilv_mode | input | 1 | 1 = staggered slots, 0 = common select |
| rd_len | input | 6 | Requested bits per read, limited to 1..31 |
| sck_div | input | 8 | Serial clock half-period in system cycles |
| sdo | input | N | Serial data from each converter (may be tied together in staggered mode) |
| cs_n | output | N | Active-low chip-selects; rising edge starts a conversion |
| sck | output | 1 | Shared serial clock, idles low |
| out_valid | output | 1 | Result word available |
| out_ready | input | 1 | Consumer takes the word when high with out_valid |
| out_data | output | 31 | Result bits, right-aligned |
| out_chan | output | $clog2(N) | Channel of the result word |
| ovf | output | 1 | One-cycle pulse per dropped word |

## Verification
A slot start seen in IDLE pulls the chip-select low on that same edge. The first serial rising edge follows `1 + sck_div` edges later. The release edge comes 1 + 2·n·`sck_div` edges after the slot start, and the first word reaches `out_valid` on the following edge. The bench measures spacing and pulse widths from edges it sees at the falling system-clock edge, where every registered output has settled. It waits whole periods before it counts words and overflow pulses. Results that depend on `out_ready` are read one time step after a rising edge, so the handshake is fixed before the design samples it.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    localparam int unsigned WORD_MAX = 31;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SELECT,
        ST_SHIFT,
        ST_DRAIN
    } rd_state_e;

    function automatic logic [4:0] clamp_len(input logic [5:0] req);
        if (req == 6'd0) return 5'd1;
        if (req > 6'd31) return 5'd31;
        return req[4:0];
    endfunction

endpackage

// File: rtl/ilv_slot_sched.sv
module ilv_slot_sched #(
    parameter int N        = 4,
    parameter int PERIOD   = 402,
    parameter int CONV_CYC = 300,
    localparam int IW      = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ilv,
    input  logic [N-1:0]  rise_mask,
    output logic          start,
    output logic [IW-1:0] start_idx,
    output logic [N-1:0]  ready_mask
);

    localparam int PW  = $clog2(PERIOD);
    localparam int SPC = PERIOD / N;
    localparam int AW  = $clog2(CONV_CYC + 1);

    logic [PW-1:0] pcnt;
    logic [N-1:0]  hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (pcnt == PW'(PERIOD - 1)) begin
            pcnt <= '0;
        end else begin
            pcnt <= pcnt + 1'b1;
        end
    end

    for (genvar k = 0; k < N; k++) begin : g_slot
        logic [AW-1:0] age_q;

        assign hit[k] = (pcnt == PW'(k * SPC));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                age_q <= AW'(CONV_CYC);
            end else if (rise_mask[k]) begin
                age_q <= '0;
            end else if (age_q != AW'(CONV_CYC)) begin
                age_q <= age_q + 1'b1;
            end
        end

        assign ready_mask[k] = (age_q == AW'(CONV_CYC));
    end

    always_comb begin
        start     = ilv ? (|hit) : hit[0];
        start_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit[i]) start_idx = IW'(i);
        end
    end

endmodule

// File: rtl/ilv_sck_gen.sv
module ilv_sck_gen (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [7:0] div,
    input  logic [4:0] nbits,
    output logic       sck,
    output logic       rise_now,
    output logic       done
);

    logic [7:0] dc;
    logic [4:0] bcnt;
    logic       tick;

    assign tick     = run && (dc == div - 8'd1);
    assign rise_now = tick && !sck;
    assign done     = tick && sck && (bcnt == nbits);

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            dc   <= '0;
            sck  <= 1'b0;
            bcnt <= '0;
        end else if (tick) begin
            dc  <= '0;
            sck <= ~sck;
            if (!sck) bcnt <= bcnt + 5'd1;
        end else begin
            dc <= dc + 8'd1;
        end
    end

    // R4
    bits_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (bcnt <= nbits));

    // R5
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> $past(run));

endmodule

// File: rtl/ilv_lane_bank.sv
module ilv_lane_bank #(
    parameter int N = 4,
    parameter int W = 31
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                shift,
    input  logic [N-1:0]        en,
    input  logic [N-1:0]        sdo,
    output logic [N-1:0][W-1:0] words
);

    for (genvar g = 0; g < N; g++) begin : g_lane
        logic [W-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                lane_q <= '0;
            end else if (shift && en[g]) begin
                lane_q <= {lane_q[W-2:0], sdo[g]};
            end
        end

        assign words[g] = lane_q;
    end

endmodule

// File: rtl/ilv_adc_rdctl.sv
module ilv_adc_rdctl
    import ilv_pkg::*;
#(
    parameter int N        = 4,
    parameter int PERIOD   = 402,
    parameter int CONV_CYC = 300,
    localparam int IW      = (N > 1) ? $clog2(N) : 1,
    localparam int W       = WORD_MAX
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ilv_mode,
    input  logic [5:0]    rd_len,
    input  logic [7:0]    sck_div,
    input  logic [N-1:0]  sdo,
    output logic [N-1:0]  cs_n,
    output logic          sck,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [W-1:0]  out_data,
    output logic [IW-1:0] out_chan,
    output logic          ovf
);

    rd_state_e state, nxt;

    logic                start;
    logic [IW-1:0]       start_idx;
    logic [N-1:0]        ready_mask, sel_mask, mask_q, rise_mask;
    logic                ilv_q;
    logic [4:0]          nbits_q;
    logic [7:0]          div_q;
    logic [IW-1:0]       didx;
    logic                sck_rise, sck_done;
    logic [N-1:0][W-1:0] words;
    logic                go, emit, free;

    always_comb begin
        sel_mask = (ilv_mode ? (N'(1) << start_idx) : {N{1'b1}}) & ready_mask;
        go       = (state == ST_IDLE) && start && (|sel_mask);
        emit     = (state == ST_DRAIN) && mask_q[didx];
        free     = !out_valid || out_ready;
        rise_mask = (state == ST_SHIFT && sck_done) ? mask_q : '0;
    end

    ilv_slot_sched #(.N(N), .PERIOD(PERIOD), .CONV_CYC(CONV_CYC)) u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .ilv        (ilv_mode),
        .rise_mask  (rise_mask),
        .start      (start),
        .start_idx  (start_idx),
        .ready_mask (ready_mask)
    );

    ilv_sck_gen u_sck (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state == ST_SHIFT),
        .div      (div_q),
        .nbits    (nbits_q),
        .sck      (sck),
        .rise_now (sck_rise),
        .done     (sck_done)
    );

    ilv_lane_bank #(.N(N), .W(W)) u_lanes (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state == ST_SELECT),
        .shift (sck_rise),
        .en    (mask_q),
        .sdo   (sdo),
        .words (words)
    );

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (go) nxt = ST_SELECT;
            ST_SELECT: nxt = ST_SHIFT;
            ST_SHIFT:  if (sck_done) nxt = ST_DRAIN;
            ST_DRAIN:  if (didx == IW'(N - 1)) nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_n      <= '1;
            mask_q    <= '0;
            ilv_q     <= 1'b0;
            nbits_q   <= 5'd1;
            div_q     <= 8'd1;
            didx      <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_chan  <= '0;
            ovf       <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (out_valid && out_ready) out_valid <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (go) begin
                        mask_q  <= sel_mask;
                        ilv_q   <= ilv_mode;
                        nbits_q <= clamp_len(rd_len);
                        div_q   <= (sck_div == 8'd0) ? 8'd1 : sck_div;
                        cs_n    <= ~sel_mask;
                    end
                end
                ST_SELECT: didx <= '0;
                ST_SHIFT: begin
                    if (sck_done) cs_n <= '1;
                end
                ST_DRAIN: begin
                    if (emit) begin
                        if (free) begin
                            out_valid <= 1'b1;
                            out_data  <= words[didx];
                            out_chan  <= didx;
                        end else begin
                            ovf <= 1'b1;
                        end
                    end
                    didx <= didx + 1'b1;
                end
            endcase
        end
    end

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_chan)));

    // R8
    drop_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> $past(out_valid && !out_ready));

    // R10
    one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ilv_q |-> $onehot0(~cs_n));

    // R4
    sck_framed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck) |-> !(&cs_n));

endmodule

// File: tb/ilv_adc_rdctl_test.sv
`timescale 1ns/1ps
module ilv_adc_rdctl_test;

    localparam int N      = 4;
    localparam int PERIOD = 402;
    localparam int CONV   = 300;
    localparam int SPC    = PERIOD / N;
    localparam int REM    = PERIOD - SPC * N;
    localparam int NV     = 9;

    // {expected words, staggered, rd_len, sck_div}
    localparam logic [19:0] VECS [NV] = '{
        {5'd12, 1'b1, 6'd24, 8'd1},
        {5'd12, 1'b1, 6'd31, 8'd1},
        {5'd12, 1'b1, 6'd40, 8'd1},
        {5'd12, 1'b1, 6'd0,  8'd1},
        {5'd12, 1'b1, 6'd8,  8'd3},
        {5'd12, 1'b1, 6'd12, 8'd0},
        {5'd12, 1'b0, 6'd16, 8'd1},
        {5'd12, 1'b0, 6'd31, 8'd1},
        {5'd8,  1'b0, 6'd31, 8'd2}
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic         ilv_mode;
    logic [5:0]   rd_len;
    logic [7:0]   sck_div;
    logic [N-1:0] sdo;
    logic [N-1:0] cs_n;
    logic         sck;
    logic         out_valid;
    logic         out_ready;
    logic [30:0]  out_data;
    logic [1:0]   out_chan;
    logic         ovf;

    always #2.5 clk = ~clk;

    ilv_adc_rdctl #(.N(N), .PERIOD(PERIOD), .CONV_CYC(CONV)) uut (
        .clk(clk), .rst_n(rst_n), .ilv_mode(ilv_mode), .rd_len(rd_len),
        .sck_div(sck_div), .sdo(sdo), .cs_n(cs_n), .sck(sck),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_chan(out_chan), .ovf(ovf)
    );

    int n_chk = 0, n_err = 0, m_chk = 0, m_err = 0;
    int eff_n = 16, eff_div = 1;
    bit cfg_ilv = 1'b1, chk_order = 1'b1;

    function automatic logic [31:0] pat(input int ch);
        return 32'hB4E1_6C2D ^ (32'h0F1E_2D3C * 32'(ch + 1));
    endfunction

    task automatic chk(input string tag, input longint got, input longint exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic mchk(input string tag, input longint got, input longint exp);
        m_chk++;
        if (got != exp) begin
            m_err++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // converter model and monitor
    logic [N-1:0] sbit = '0;
    assign sdo = sbit;
    int ptr [N], rises [N], falls [N];
    logic [N-1:0] prev_cs = '1;
    logic prev_sck = 1'b0;
    longint cyc = 0, last_cyc = 0, hi_at = 0;
    int last_ch = 0, exp_ch = 0, word_cnt = 0, ovf_cnt = 0;
    bit have_last = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (!rst_n) begin
            have_last = 1'b0;
            exp_ch    = 0;
            word_cnt  = 0;
            ovf_cnt   = 0;
            sbit      = '0;
            for (int c = 0; c < N; c++) begin
                rises[c] = 0;
                falls[c] = 0;
                ptr[c]   = 31;
            end
        end else begin
            if (!prev_sck && sck) hi_at = cyc;
            if (prev_sck && !sck) mchk("R5 sck high width", cyc - hi_at, eff_div);
            for (int ch = 0; ch < N; ch++) begin
                logic [31:0] w;
                w = pat(ch);
                if (prev_cs[ch] && !cs_n[ch]) begin
                    ptr[ch]   = 31;
                    sbit[ch]  = w[31];
                    rises[ch] = 0;
                    falls[ch] = 0;
                end
                if (!prev_cs[ch]) begin
                    if (!prev_sck && sck) rises[ch]++;
                    if (prev_sck && !sck) begin
                        falls[ch]++;
                        if (ptr[ch] > 0) ptr[ch]--;
                        sbit[ch] = w[ptr[ch]];
                    end
                end
                if (!prev_cs[ch] && cs_n[ch]) begin
                    mchk("R4 rising sck edges per read", rises[ch], eff_n);
                    mchk("R4 falling sck edges per read", falls[ch], eff_n);
                    if (cfg_ilv) begin
                        if (have_last) begin
                            mchk("R2 release spacing", cyc - last_cyc,
                                 (ch == 0) ? SPC + REM : SPC);
                            mchk("R2 release order", ch, (last_ch + 1) % N);
                        end
                        have_last = 1'b1;
                        last_cyc  = cyc;
                        last_ch   = ch;
                    end else begin
                        mchk("R3 common release", cs_n, {N{1'b1}});
                    end
                end
            end
            if (out_valid && out_ready) begin
                logic [31:0] wv;
                wv = pat(int'(out_chan));
                mchk("R6 word value", out_data, 31'(wv >> (32 - eff_n)));
                if (chk_order) begin
                    mchk("R3 channel order", out_chan, exp_ch);
                    exp_ch = (exp_ch + 1) % N;
                end
                word_cnt++;
            end
            if (ovf) ovf_cnt++;
        end
        prev_cs  = cs_n;
        prev_sck = sck;
    end

    task automatic start_cfg(input bit ilv, input logic [5:0] len, input logic [7:0] dv);
        @(posedge clk); #1;
        rst_n    = 1'b0;
        ilv_mode = ilv;
        rd_len   = len;
        sck_div  = dv;
        cfg_ilv  = ilv;
        eff_n    = (len == 0) ? 1 : (len > 31) ? 31 : int'(len);
        eff_div  = (dv == 0) ? 1 : int'(dv);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 cs_n in reset", cs_n, {N{1'b1}});
        chk("R1 sck in reset", sck, 0);
        chk("R1 out_valid in reset", out_valid, 0);
        chk("R1 ovf in reset", ovf, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; ilv_mode = 1'b1; rd_len = 6'd16; sck_div = 8'd1; out_ready = 1'b1;

        for (int v = 0; v < NV; v++) begin
            logic [19:0] vec;
            vec = VECS[v];
            out_ready = 1'b1;
            chk_order = 1'b1;
            start_cfg(vec[14], vec[13:8], vec[7:0]);
            repeat (3 * PERIOD) @(posedge clk);
            #1;
            chk(vec[14] ? "R2 R9 words in three periods" : "R3 R9 words in three periods",
                word_cnt, vec[19:15]);
            chk("R8 no drops with ready high", ovf_cnt, 0);
        end

        // staggered mode, consumer stalled
        out_ready = 1'b0;
        chk_order = 1'b0;
        start_cfg(1'b1, 6'd16, 8'd1);
        repeat (PERIOD + 8) @(posedge clk);
        #1;
        chk("R8 drops in staggered stall", ovf_cnt, 3);
        chk("R7 held valid", out_valid, 1);
        chk("R7 held channel", out_chan, 0);
        chk("R7 held word", out_data, 31'(pat(0) >> 16));
        out_ready = 1'b1;
        @(posedge clk); #1;
        chk("R7 word taken on ready", word_cnt, 1);
        chk("R7 valid drops after take", out_valid, 0);

        // common mode, consumer stalled
        out_ready = 1'b0;
        start_cfg(1'b0, 6'd8, 8'd1);
        repeat (40) @(posedge clk);
        #1;
        chk("R8 drops in common stall", ovf_cnt, 3);
        chk("R7 first channel kept", out_chan, 0);
        chk("R7 valid kept", out_valid, 1);
        out_ready = 1'b1;
        repeat (4) @(posedge clk);

        $display("Result: errors=%0d of %0d checks", n_err + m_err, n_chk + m_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err + m_err + 1, n_chk + m_chk + 1);
        $finish;
    end

endmodule